// File: doc/BRIEF.md
# Pseudo-SRAM Write and Deep Power-Down Controller

A synchronous controller for an asynchronous pseudo-static RAM of 2M words by 16 bits (21-bit address, 16-bit data). A host hands it one write at a time. The controller turns each write into a timed strobe sequence on the memory pins. First the address is set up. Then chip-select and write-enable are low together for the write pulse, with the upper and/or lower byte-select low as the request asks. The data is held on the bus past the end of the pulse. A recovery period keeps the address unchanged, and the whole cycle is never shorter than the minimum write cycle. Every interval is a parameter counted in clock cycles.

The controller also drives the memory's active-low sleep pin. When `sleep_req` is high and no write is in flight, it pulls the pin low and waits out a suspend period before it reports power-down. When `sleep_req` falls, it raises the pin and waits a wake-up period, which is the same length as the power-up wait that follows reset. No write is started during any of these periods.

The host port uses valid/ready with completion acknowledge. The host raises `req_valid` with address, data and byte enables, and keeps all of them stable until it sees `req_ready`. `req_ready` is a one-cycle pulse issued only after the memory cycle, recovery included, has finished. The transfer takes place on the edge where both are high. The host may keep `req_valid` high with a new payload to queue the next write.

Top module: `psram_wr_ctrl`

## Requirements
- R1: After reset, `stat_ready` stays low for exactly WAKE_CYC cycles. During that time all strobes stay high and no request is accepted.
- R2: A write presents the request address on `mem_addr` for AS_CYC cycles with `mem_cs_n` and `mem_we_n` high. The write interval starts after that.
- R3: During the write interval, `mem_cs_n` and `mem_we_n` are both low for exactly WP_CYC consecutive cycles.
- R4: `req_be[1]` selects the upper byte (`mem_ub_n` low) and `req_be[0]` selects the lower byte (`mem_lb_n` low). A byte-select is low only inside the write interval. When `req_be` is 0, both byte-selects stay high.
- R5: `mem_dq_oe` is high from the first cycle of the write interval until DH_CYC cycles after it ends. While it is high, `mem_dq_out` carries the request data.
- R6: `mem_addr` stays unchanged from the start of the write until the acknowledge. The recovery period after the write interval lasts max(WR_CYC, WC_CYC-AS_CYC-WP_CYC) cycles. The whole cycle lasts at least WC_CYC cycles.
- R7: `req_ready` is a single-cycle pulse in the cycle right after recovery. It is the (AS_CYC+WP_CYC+recovery+1)-th cycle after the edge that accepted the request.
- R8: When `sleep_req` is seen in idle, `mem_sleep_n` goes low in the next cycle. `stat_pd` rises SUSP_CYC cycles after that.
- R9: When `sleep_req` falls during power-down, `mem_sleep_n` goes high in the next cycle. `stat_ready` returns WAKE_CYC cycles after that.
- R10: A `sleep_req` raised during a write is deferred until the acknowledge. `sleep_req` takes priority over a pending request in idle. No request is accepted during suspend, power-down or wake-up.
- R11: While `mem_sleep_n` is low and during wake-up, all strobes are high and `mem_dq_oe` is low.
- R12: `stat_busy` is high from the edge that accepts a request through the acknowledge cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Completion acknowledge, one cycle |
| req_addr | input | 21 | Word address |
| req_data | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 1 upper, bit 0 lower |
| sleep_req | input | 1 | Level request for deep power-down |
| stat_ready | output | 1 | Idle and able to accept a write |
| stat_busy | output | 1 | Write cycle in progress |
| stat_pd | output | 1 | Memory is in deep power-down |
| mem_addr | output | 21 | Memory address |
| mem_dq_out | output | 16 | Data driven towards memory |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_ub_n | output | 1 | Upper byte-select, active low |
| mem_lb_n | output | 1 | Lower byte-select, active low |
| mem_sleep_n | output | 1 | Sleep pin, low requests power-down |

## Verification
All behaviour runs off one sequencer state and one down-counter. If the state is wrong, a strobe is low in the wrong cycle, or `mem_dq_oe` or `mem_sleep_n` changes at the wrong time, within one cycle of the fault. If the counter is off, the write pulse is too short or too long, the acknowledge moves, or the suspend or wake-up length changes, and this shows at the end of the interval concerned. The sweep over all byte-enable values and several address and data patterns checks each pin cycle by cycle against counts computed from the parameters.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [3:0] {
    ST_PWRUP = 4'd0,
    ST_IDLE  = 4'd1,
    ST_SETUP = 4'd2,
    ST_PULSE = 4'd3,
    ST_RECOV = 4'd4,
    ST_DONE  = 4'd5,
    ST_SUSP  = 4'd6,
    ST_PD    = 4'd7,
    ST_WAKE  = 4'd8
  } ctl_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_tmr.sv
module psram_tmr #(
  parameter int unsigned TW      = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= TW'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  a_r6_tmr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r6_tmr_park: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int unsigned TW       = 16,
  parameter int unsigned AS_CYC   = 1,
  parameter int unsigned WP_CYC   = 11,
  parameter int unsigned REC_LEN  = 2,
  parameter int unsigned SUSP_CYC = 100,
  parameter int unsigned WAKE_CYC = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          sleep_req,
  input  logic          tmr_done,
  output ctl_state_e    state_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          start
);
  ctl_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRUP: if (tmr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (sleep_req)      state_d = ST_SUSP;
        else if (req_valid) state_d = ST_SETUP;
      end
      ST_SETUP: if (tmr_done) state_d = ST_PULSE;
      ST_PULSE: if (tmr_done) state_d = ST_RECOV;
      ST_RECOV: if (tmr_done) state_d = ST_DONE;
      ST_DONE:                state_d = ST_IDLE;
      ST_SUSP:  if (tmr_done) state_d = ST_PD;
      ST_PD:    if (!sleep_req) state_d = ST_WAKE;
      ST_WAKE:  if (tmr_done) state_d = ST_IDLE;
      default:                state_d = ST_PWRUP;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP: tmr_val = TW'(AS_CYC - 1);
      ST_PULSE: tmr_val = TW'(WP_CYC - 1);
      ST_RECOV: tmr_val = TW'(REC_LEN - 1);
      ST_SUSP:  tmr_val = TW'(SUSP_CYC - 1);
      ST_WAKE:  tmr_val = TW'(WAKE_CYC - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign start    = (state_q == ST_IDLE) && (state_d == ST_SETUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWRUP;
    else        state_q <= state_d;
  end

  a_r10_sleep_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sleep_req) |=> (state_q == ST_SUSP));
  a_r3_pulse_ends_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_PULSE && state_q != ST_PULSE) |-> $past(tmr_done));
  a_r8_pd_from_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD && $past(state_q) != ST_PD) |-> ($past(state_q) == ST_SUSP && $past(tmr_done)));
  a_r10_write_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV) |=> (state_q == ST_RECOV || state_q == ST_DONE));
endmodule

// File: rtl/psram_wr_ctrl.sv
module psram_wr_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned AW       = 21,
  parameter int unsigned DW       = 16,
  parameter int unsigned AS_CYC   = 1,
  parameter int unsigned WP_CYC   = 11,
  parameter int unsigned WR_CYC   = 1,
  parameter int unsigned DH_CYC   = 1,
  parameter int unsigned WC_CYC   = 14,
  parameter int unsigned SUSP_CYC = 100,
  parameter int unsigned WAKE_CYC = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [DW/8-1:0] req_be,
  input  logic          sleep_req,
  output logic          stat_ready,
  output logic          stat_busy,
  output logic          stat_pd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_sleep_n
);
  localparam int unsigned NB      = DW / 8;
  localparam int unsigned REC_LEN = imax(WR_CYC, (WC_CYC > AS_CYC + WP_CYC) ? WC_CYC - AS_CYC - WP_CYC : 1);
  localparam int unsigned MAXLEN  = imax(imax(WAKE_CYC, SUSP_CYC), imax(imax(AS_CYC, WP_CYC), REC_LEN));
  localparam int unsigned TW      = $clog2(MAXLEN + 1);
  localparam logic [TW-1:0] DH_EDGE = TW'(REC_LEN - DH_CYC);

  ctl_state_e    state_q;
  logic          tmr_load, tmr_done, start;
  logic [TW-1:0] tmr_val, tmr_cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [NB-1:0] be_q;
  logic          in_pulse, in_hold;

  psram_seq #(
    .TW(TW), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .REC_LEN(REC_LEN),
    .SUSP_CYC(SUSP_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sleep_req(sleep_req),
    .tmr_done(tmr_done), .state_q(state_q), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .start(start)
  );

  psram_tmr #(.TW(TW), .RST_VAL(WAKE_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .done(tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (start) begin
      addr_q <= req_addr;
      data_q <= req_data;
      be_q   <= req_be;
    end
  end

  assign in_pulse = (state_q == ST_PULSE);
  assign in_hold  = (state_q == ST_RECOV) && (tmr_cnt >= DH_EDGE);

  assign mem_addr    = addr_q;
  assign mem_dq_out  = data_q;
  assign mem_dq_oe   = in_pulse || in_hold;
  assign mem_cs_n    = !in_pulse;
  assign mem_we_n    = !in_pulse;
  assign mem_ub_n    = !(in_pulse && be_q[NB-1]);
  assign mem_lb_n    = !(in_pulse && be_q[0]);
  assign mem_sleep_n = !(state_q == ST_SUSP || state_q == ST_PD);

  assign req_ready  = (state_q == ST_DONE);
  assign stat_ready = (state_q == ST_IDLE);
  assign stat_pd    = (state_q == ST_PD);
  assign stat_busy  = (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                      (state_q == ST_RECOV) || (state_q == ST_DONE);

  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_busy && $past(stat_busy)) |-> $stable(mem_addr));
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));
  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sleep_n |-> (mem_cs_n && mem_we_n && !mem_dq_oe));
  a_r4_lane_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ub_n || !mem_lb_n) |-> (stat_busy && !mem_we_n));
  a_r2_setup_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> ($past(stat_busy) && $past(mem_we_n)));
endmodule

// File: tb/psram_wr_ctrl_bench.sv
`timescale 1ns/1ps
module psram_wr_ctrl_bench;
  localparam int AS = 2, WP = 3, WR = 2, DH = 1, WC = 10, SU = 6, WK = 20;
  localparam int RL = (WR > WC - AS - WP) ? WR : WC - AS - WP;
  localparam int ACK_K = AS + WP + RL + 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, sleep_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, stat_ready, stat_busy, stat_pd;
  logic [20:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe, mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n, mem_sleep_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  psram_wr_ctrl #(.AS_CYC(AS), .WP_CYC(WP), .WR_CYC(WR), .DH_CYC(DH), .WC_CYC(WC),
                  .SUSP_CYC(SU), .WAKE_CYC(WK)) u_psram_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be), .sleep_req(sleep_req),
    .stat_ready(stat_ready), .stat_busy(stat_busy), .stat_pd(stat_pd),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_sleep_n(mem_sleep_n));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit quiet();
    return mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe;
  endfunction

  // One write; optional sleep_req raised at negedge k == sleep_k (0 = never)
  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be,
                          input int sleep_k);
    int k = 0, cs_lo = 0, we_lo = 0, ub_lo = 0, lb_lo = 0, oe_n = 0, first_lo = 0;
    int bad_addr = 0, bad_dq = 0, bad_busy = 0, bad_setup = 0, bad_sleep = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
    while (!req_ready && k < 100) begin
      @(negedge clk);
      k++;
      if (k == sleep_k) sleep_req = 1'b1;
      if (!mem_cs_n) begin cs_lo++; if (first_lo == 0) first_lo = k; end
      if (!mem_we_n) we_lo++;
      if (!mem_ub_n) ub_lo++;
      if (!mem_lb_n) lb_lo++;
      if (mem_dq_oe) begin
        oe_n++;
        if (mem_dq_out !== d) bad_dq++;
        if (k < AS + 1 || k > AS + WP + DH) bad_dq++;
      end
      if (mem_addr !== a) bad_addr++;
      if (!stat_busy) bad_busy++;
      if (!mem_sleep_n) bad_sleep++;
      if (k <= AS && !(mem_cs_n && mem_we_n)) bad_setup++;
      if (!mem_cs_n && (mem_cs_n !== mem_we_n)) bad_setup++;
    end
    chk(first_lo == AS + 1 && bad_setup == 0, "R2 setup before write", first_lo, AS + 1);
    chk(cs_lo == WP && we_lo == WP, "R3 pulse width", cs_lo, WP);
    chk(ub_lo == (be[1] ? WP : 0), "R4 upper lane", ub_lo, be[1] ? WP : 0);
    chk(lb_lo == (be[0] ? WP : 0), "R4 lower lane", lb_lo, be[0] ? WP : 0);
    chk(oe_n == WP + DH && bad_dq == 0, "R5 data window", oe_n, WP + DH);
    chk(bad_addr == 0 && k >= WC, "R6 address hold and cycle", bad_addr, 0);
    chk(k == ACK_K, "R7 ack cycle", k, ACK_K);
    chk(bad_busy == 0, "R12 busy during write", bad_busy, 0);
    chk(bad_sleep == 0, "R10 sleep deferred during write", bad_sleep, 0);
    @(negedge clk);
    chk(!req_ready && !stat_busy, "R7 R12 ack single", req_ready, 0);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    logic [20:0] pa;
    logic [15:0] pd;
    repeat (3) @(negedge clk);
    chk(!stat_ready && quiet() && mem_sleep_n, "R1 reset state", stat_ready, 0);
    rst_n = 1'b1;
    req_valid = 1'b1; req_addr = 21'h1; req_be = 2'b11;
    bad = 0;
    for (int k = 1; k < WK; k++) begin
      @(negedge clk);
      if (k == WK - 2) req_valid = 1'b0;
      if (stat_ready || !quiet() || req_ready) bad++;
    end
    chk(bad == 0, "R1 power-up wait", bad, 0);
    @(negedge clk);
    chk(stat_ready, "R1 ready after power-up", stat_ready, 1);
    @(negedge clk);
    chk(quiet() && !stat_busy, "R1 stale request ignored", stat_busy, 0);

    for (int be = 0; be < 4; be++)
      for (int p = 0; p < 4; p++) begin
        pa = 21'((p * 21'h0A5A5 + be * 21'h13579) ^ (p[0] ? 21'h1FFFFF : 21'h0));
        pd = 16'((p * 16'h3C3C) ^ (be * 16'h0F0F) ^ 16'h5A00);
        do_write(pa, pd, 2'(be), 0);
      end

    // R8 sleep entry with pending request: sleep wins (R10)
    @(negedge clk);
    sleep_req = 1'b1; req_valid = 1'b1; req_addr = 21'h7; req_be = 2'b11;
    bad = 0;
    for (int k = 1; k <= SU; k++) begin
      @(negedge clk);
      if (mem_sleep_n || stat_pd || stat_busy || !quiet()) bad++;
    end
    chk(bad == 0, "R8 R10 R11 suspend", bad, 0);
    @(negedge clk);
    chk(stat_pd && !mem_sleep_n, "R8 power-down reached", stat_pd, 1);
    repeat (5) @(negedge clk);
    chk(stat_pd && quiet() && !req_ready, "R10 request ignored in power-down", req_ready, 0);
    req_valid = 1'b0;
    sleep_req = 1'b0;
    bad = 0;
    for (int k = 1; k <= WK; k++) begin
      @(negedge clk);
      if (!mem_sleep_n || stat_ready || stat_pd || !quiet()) bad++;
      if (k == WK - 3) req_valid = 1'b1;
      if (k == WK - 1) req_valid = 1'b0;
    end
    chk(bad == 0, "R9 R11 wake-up", bad, 0);
    @(negedge clk);
    chk(stat_ready && mem_sleep_n, "R9 ready after wake", stat_ready, 1);

    // R10 sleep raised mid-write is deferred
    do_write(21'h12345, 16'hBEEF, 2'b10, 4);
    chk(mem_sleep_n, "R10 pin high just after ack", mem_sleep_n, 1);
    @(negedge clk);
    chk(!mem_sleep_n, "R10 suspend after deferral", mem_sleep_n, 0);
    sleep_req = 1'b0;
    repeat (SU + WK + 4) @(negedge clk);
    chk(stat_ready, "R9 back to idle", stat_ready, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule